// File: doc/BRIEF.md
# Configuration Load and Startup Sequencer

This block is the control state machine behind a programmable device's configuration port. After power-on reset, or after a qualified low pulse on the active-low program pin, it runs a memory-clearing phase. During that phase it pulls the shared open-drain INIT line low. When clearing is finished it lets go of the line. Any external agent that keeps INIT low, or that keeps the program pin low, holds the block in the clearing and waiting phase. The mode pins are captured on the low-to-high edge of the synchronized INIT level.

Once INIT is high, the block passes configuration frames through to the configuration memory write port. A frame marked as last carries the result of an on-chip CRC comparison. If the CRC matches, the block runs a four-step startup sequence, one step per clock. The steps, in this order, are: DONE goes high, the global three-state is released, global set/reset is negated, and global write enable is asserted. If the CRC does not match, the block enters a latched error state with INIT pulled low. Only a program pulse or a power-on reset leaves that state.

The program pin and the INIT read-back both pass through a synchronizer before any edge detection or pulse-width counting. The timing limits are given in nanoseconds and turned into cycle counts using the clock period parameter.

Top module: `cfg_boot_seq`

## Requirements
- R1: While `por_n` is low, and for `POR_CYCLES` cycles after it rises, the outputs are `init_pull`=1, `done`=0, `gts`=1, `gsr`=1, `gwe`=0 and `frame_err`=0.
- R2: During memory clearing `init_pull` is 1. Clearing lasts at least `CLEAR_CYCLES` cycles, and it continues for as long as the synchronized program pin is low.
- R3: After clearing, `init_pull` goes to 0. While the resolved `init_pin` is held low by another driver, the block keeps waiting and no frame is accepted.
- R4: `boot_mode` takes the value of `mode_pin` at the cycle where the synchronized INIT level rises. Mode pin changes before or after that cycle have no effect.
- R5: `cfg_we` equals `frm_valid` only in the load phase, which is entered after INIT has been seen high. In every other phase `cfg_we` is 0. `cfg_wdata` carries `frm_data`.
- R6: A beat with `frm_valid`=1, `frm_last`=1 and `crc_ok`=0 makes the block enter an error state. In that state `frame_err`=1, `init_pull`=1, `done`=0 and `cfg_we`=0. The state holds until a qualified program pulse or a power-on reset.
- R7: A qualified program pulse, or `por_n` going low, returns the block from any state to the clearing or reset state. Then `init_pull`=1, `done`=0, `gts`=1, `gsr`=1, `gwe`=0 and `frame_err`=0.
- R8: A beat with `frm_valid`=1, `frm_last`=1 and `crc_ok`=1 starts the startup sequence, one step per cycle. `done` rises in the cycle after that beat, `gts` falls one cycle later, `gsr` falls one cycle after that, and `gwe` rises one cycle after that.
- R9: A low pulse on `prog_n` that lasts fewer than `ceil(PROG_MIN_NS/CLK_PERIOD_NS)` synchronized cycles has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| prog_n | input | 1 | Program pin, active low, asynchronous |
| init_pin | input | 1 | Resolved level of the open-drain INIT line |
| mode_pin | input | MODE_W | Configuration mode pins |
| frm_data | input | DATA_W | Configuration frame word |
| frm_valid | input | 1 | Frame word present |
| frm_last | input | 1 | Final word of the configuration stream |
| crc_ok | input | 1 | CRC comparison result, valid with the last word |
| init_pull | output | 1 | Pull-low enable for the INIT line |
| done | output | 1 | Configuration complete |
| gts | output | 1 | Global three-state, 1 keeps user I/O in high impedance |
| gsr | output | 1 | Global set/reset, 1 holds flip-flops in reset |
| gwe | output | 1 | Global write enable for RAMs and flip-flops |
| frame_err | output | 1 | CRC mismatch, configuration aborted |
| boot_mode | output | MODE_W | Mode pins captured on the INIT rising edge |
| cfg_we | output | 1 | Write strobe to configuration memory |
| cfg_wdata | output | DATA_W | Write data to configuration memory |

## Verification
The first boot is run with INIT held low by an outside driver well after internal clearing has ended. This separates the block's own release of the line from acceptance of frames. The mode pins are given one value while INIT is held and a different value just after release, which shows that capture happens only on the edge. A matching CRC and a mismatching CRC are then applied, to separate the cycle-by-cycle startup order from the latched abort. Program pulses just under and well over the qualifying width, plus a program pin held low past the clearing length and a power-on reset in mid-run, show which events restart configuration.

// File: rtl/cfg_boot_pkg.sv
package cfg_boot_pkg;

   typedef enum logic [3:0] {
      ST_POR     = 4'd0,
      ST_CLR     = 4'd1,
      ST_WAIT    = 4'd2,
      ST_LOAD    = 4'd3,
      ST_SU_DONE = 4'd4,
      ST_SU_IO   = 4'd5,
      ST_SU_RST  = 4'd6,
      ST_RUN     = 4'd7,
      ST_ERR     = 4'd8
   } boot_st_e;

endpackage

// File: rtl/cfg_boot_sync.sv
module cfg_boot_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("cfg_boot_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= {STAGES{RST_VAL}};
      else        sr <= {sr[STAGES-2:0], d};
   end

   assign q = sr[STAGES-1];

endmodule

// File: rtl/cfg_boot_pulse.sv
module cfg_boot_pulse #(
   parameter int MIN_CYC = 30
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_n,
   output logic qual
);

   localparam int CW = $clog2(MIN_CYC + 1);

   if (MIN_CYC < 1) begin : g_bad_min
      $error("cfg_boot_pulse: MIN_CYC must be positive");
   end

   logic [CW-1:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        low_cnt <= '0;
      else if (lvl_n)                    low_cnt <= '0;
      else if (low_cnt != CW'(MIN_CYC))  low_cnt <= low_cnt + 1'b1;
   end

   assign qual = (low_cnt == CW'(MIN_CYC));

endmodule

// File: rtl/cfg_boot_seq.sv
module cfg_boot_seq
   import cfg_boot_pkg::*;
#(
   parameter int CLK_PERIOD_NS   = 10,
   parameter int PROG_MIN_NS     = 300,
   parameter int PROG_LAT_MAX_NS = 100000,
   parameter int POR_MAX_NS      = 2000000,
   parameter int POR_CYCLES      = 1000,
   parameter int CLEAR_CYCLES    = 512,
   parameter int MODE_W          = 3,
   parameter int DATA_W          = 32,
   parameter int SYNC_STAGES     = 2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              prog_n,
   input  logic              init_pin,
   input  logic [MODE_W-1:0] mode_pin,
   input  logic [DATA_W-1:0] frm_data,
   input  logic              frm_valid,
   input  logic              frm_last,
   input  logic              crc_ok,
   output logic              init_pull,
   output logic              done,
   output logic              gts,
   output logic              gsr,
   output logic              gwe,
   output logic              frame_err,
   output logic [MODE_W-1:0] boot_mode,
   output logic              cfg_we,
   output logic [DATA_W-1:0] cfg_wdata
);

   localparam int PROG_MIN_CYC = (PROG_MIN_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
   localparam int LAT_MAX_CYC  = PROG_LAT_MAX_NS / CLK_PERIOD_NS;
   localparam int POR_MAX_CYC  = POR_MAX_NS / CLK_PERIOD_NS;
   localparam int PROG_LAT_CYC = SYNC_STAGES + PROG_MIN_CYC + 1;
   localparam int CNT_MAX      = (POR_CYCLES > CLEAR_CYCLES) ? POR_CYCLES : CLEAR_CYCLES;
   localparam int CNT_W        = $clog2(CNT_MAX + 1);

   if (CLK_PERIOD_NS < 1) begin : g_bad_clk
      $error("cfg_boot_seq: CLK_PERIOD_NS must be positive");
   end
   if (POR_CYCLES < 1 || POR_CYCLES > POR_MAX_CYC) begin : g_bad_por
      $error("cfg_boot_seq: POR_CYCLES outside the power-on limit");
   end
   if (CLEAR_CYCLES < SYNC_STAGES + 1) begin : g_bad_clear
      $error("cfg_boot_seq: CLEAR_CYCLES too short to flush INIT synchronizer");
   end
   if (PROG_LAT_CYC > LAT_MAX_CYC) begin : g_bad_lat
      $error("cfg_boot_seq: program latency exceeds its limit");
   end
   if (MODE_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("cfg_boot_seq: widths must be positive");
   end

   logic prog_s, prog_hold, init_s, init_d, init_rise;

   cfg_boot_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_prog_sync (
      .clk(clk), .rst_n(por_n), .d(prog_n), .q(prog_s));

   cfg_boot_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_init_sync (
      .clk(clk), .rst_n(por_n), .d(init_pin), .q(init_s));

   cfg_boot_pulse #(.MIN_CYC(PROG_MIN_CYC)) u_prog_qual (
      .clk(clk), .rst_n(por_n), .lvl_n(prog_s), .qual(prog_hold));

   boot_st_e          st, st_nx;
   logic [CNT_W-1:0]  cnt, cnt_nx;
   logic              cap;

   assign init_rise = init_s & ~init_d;

   always_comb begin
      st_nx  = st;
      cnt_nx = cnt;
      cap    = 1'b0;
      if (prog_hold) begin
         st_nx  = ST_CLR;
         cnt_nx = '0;
      end else begin
         case (st)
            ST_POR: begin
               if (cnt == CNT_W'(POR_CYCLES - 1)) begin
                  st_nx  = ST_CLR;
                  cnt_nx = '0;
               end else begin
                  cnt_nx = cnt + 1'b1;
               end
            end
            ST_CLR: begin
               if (cnt != CNT_W'(CLEAR_CYCLES - 1)) cnt_nx = cnt + 1'b1;
               else if (prog_s)                     st_nx  = ST_WAIT;
            end
            ST_WAIT: begin
               if (init_rise) begin
                  st_nx = ST_LOAD;
                  cap   = 1'b1;
               end
            end
            ST_LOAD: begin
               if (frm_valid && frm_last) st_nx = crc_ok ? ST_SU_DONE : ST_ERR;
            end
            ST_SU_DONE: st_nx = ST_SU_IO;
            ST_SU_IO:   st_nx = ST_SU_RST;
            ST_SU_RST:  st_nx = ST_RUN;
            default:    st_nx = st;
         endcase
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         st        <= ST_POR;
         cnt       <= '0;
         init_d    <= 1'b0;
         boot_mode <= '0;
      end else begin
         st     <= st_nx;
         cnt    <= cnt_nx;
         init_d <= init_s;
         if (cap) boot_mode <= mode_pin;
      end
   end

   assign init_pull = (st == ST_POR) || (st == ST_CLR) || (st == ST_ERR);
   assign done      = (st == ST_SU_DONE) || (st == ST_SU_IO) ||
                      (st == ST_SU_RST)  || (st == ST_RUN);
   assign gts       = !((st == ST_SU_IO) || (st == ST_SU_RST) || (st == ST_RUN));
   assign gsr       = !((st == ST_SU_RST) || (st == ST_RUN));
   assign gwe       = (st == ST_RUN);
   assign frame_err = (st == ST_ERR);
   assign cfg_we    = frm_valid && (st == ST_LOAD);
   assign cfg_wdata = frm_data;

endmodule

// File: rtl/cfg_boot_seq_chk.sv
module cfg_boot_seq_chk #(
   parameter int MODE_W = 3
) (
   input logic              clk,
   input logic              por_n,
   input logic              init_pull,
   input logic              done,
   input logic              gts,
   input logic              gsr,
   input logic              gwe,
   input logic              frame_err,
   input logic              cfg_we,
   input logic [MODE_W-1:0] boot_mode
);

   // R5
   load_only_released_chk: assert property (@(posedge clk) disable iff (!por_n)
      cfg_we |-> !init_pull);

   // R8
   gwe_after_gsr_chk: assert property (@(posedge clk) disable iff (!por_n)
      gwe |-> !gsr);

   // R8
   gsr_after_gts_chk: assert property (@(posedge clk) disable iff (!por_n)
      !gsr |-> !gts);

   // R8
   gts_after_done_chk: assert property (@(posedge clk) disable iff (!por_n)
      !gts |-> done);

   // R6
   err_holds_init_chk: assert property (@(posedge clk) disable iff (!por_n)
      frame_err |-> (init_pull && !done && !cfg_we));

   // R7
   done_exit_clears_chk: assert property (@(posedge clk) disable iff (!por_n)
      done |=> (done || init_pull));

   // R4
   mode_frozen_chk: assert property (@(posedge clk) disable iff (!por_n)
      done |=> $stable(boot_mode));

endmodule

bind cfg_boot_seq cfg_boot_seq_chk #(.MODE_W(MODE_W)) u_chk (
   .clk(clk), .por_n(por_n), .init_pull(init_pull), .done(done), .gts(gts),
   .gsr(gsr), .gwe(gwe), .frame_err(frame_err), .cfg_we(cfg_we),
   .boot_mode(boot_mode));

// File: tb/cfg_boot_seq_bench.sv
module cfg_boot_seq_bench;

   localparam int CLK_NS = 10;
   localparam int POR_C  = 20;
   localparam int CLR_C  = 16;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        prog_n = 1'b1;
   logic        ext_hold = 1'b1;
   logic        init_pin;
   logic [2:0]  mode_pin = 3'b101;
   logic [31:0] frm_data = '0;
   logic        frm_valid = 1'b0;
   logic        frm_last = 1'b0;
   logic        crc_ok = 1'b0;
   logic        init_pull, done, gts, gsr, gwe, frame_err, cfg_we;
   logic [2:0]  boot_mode;
   logic [31:0] cfg_wdata;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #(CLK_NS/2) clk = ~clk;

   assign init_pin = !(init_pull || ext_hold);

   cfg_boot_seq #(
      .CLK_PERIOD_NS(CLK_NS), .POR_CYCLES(POR_C), .CLEAR_CYCLES(CLR_C),
      .MODE_W(3), .DATA_W(32)
   ) u_cfg_boot_seq (
      .clk(clk), .por_n(por_n), .prog_n(prog_n), .init_pin(init_pin),
      .mode_pin(mode_pin), .frm_data(frm_data), .frm_valid(frm_valid),
      .frm_last(frm_last), .crc_ok(crc_ok), .init_pull(init_pull), .done(done),
      .gts(gts), .gsr(gsr), .gwe(gwe), .frame_err(frame_err),
      .boot_mode(boot_mode), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // packs {init_pull, done, gts, gsr, gwe, frame_err}
   function automatic logic [31:0] outs();
      return {26'd0, init_pull, done, gts, gsr, gwe, frame_err};
   endfunction

   task automatic t_reset_and_first_boot();
      #2;
      chk("R1 in reset", outs(), 32'b101100);
      wait_cyc(3);
      por_n = 1'b1;
      wait_cyc(5);
      chk("R1 during power-on interval", outs(), 32'b101100);
      wait_cyc(25);
      chk("R2 clearing pulls INIT", {31'd0, init_pull}, 32'd1);
      wait_cyc(30);
      chk("R3 released but held externally", {30'd0, init_pull, init_pin}, 32'd0);
      frm_valid = 1'b1;
      frm_data  = 32'hdead0001;
      #1;
      chk("R5 no frame while INIT low", {31'd0, cfg_we}, 32'd0);
      frm_valid = 1'b0;
      wait_cyc(10);
      chk("R3 still waiting", {31'd0, done}, 32'd0);
      mode_pin = 3'b010;
      ext_hold = 1'b0;
      wait_cyc(6);
      mode_pin = 3'b111;
      wait_cyc(2);
      chk("R4 mode captured at INIT edge", {29'd0, boot_mode}, 32'h2);
   endtask

   task automatic load_frames(input int n, input logic good);
      int taken = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         frm_valid = 1'b1;
         frm_data  = 32'h1000 + i;
         frm_last  = (i == n - 1);
         crc_ok    = good;
         #1;
         if (cfg_we && cfg_wdata == 32'h1000 + i) taken++;
      end
      chk("R5 frames written in load phase", taken, n);
   endtask

   task automatic drop_frame();
      frm_valid = 1'b0;
      frm_last  = 1'b0;
      crc_ok    = 1'b0;
   endtask

   task automatic t_startup_order();
      load_frames(4, 1'b1);
      @(negedge clk);
      drop_frame();
      chk("R8 step1 done", outs(), 32'b011100);
      @(negedge clk);
      chk("R8 step2 three-state released", outs(), 32'b010100);
      @(negedge clk);
      chk("R8 step3 set/reset negated", outs(), 32'b010000);
      @(negedge clk);
      chk("R8 step4 write enable", outs(), 32'b010010);
   endtask

   task automatic t_short_program();
      prog_n = 1'b0;
      wait_cyc(20);
      prog_n = 1'b1;
      wait_cyc(10);
      chk("R9 short program pulse ignored", outs(), 32'b010010);
   endtask

   task automatic t_long_program(input bool_hold_long);
      prog_n = 1'b0;
      wait_cyc(40);
      chk("R7 program returns to clearing", outs(), 32'b101100);
      if (bool_hold_long) begin
         wait_cyc(CLR_C + 20);
         chk("R2 clearing extended by program", {31'd0, init_pull}, 32'd1);
      end
      prog_n = 1'b1;
      wait_cyc(30);
      chk("R3 INIT released after program", {30'd0, init_pull, init_pin}, 32'd1);
   endtask

   task automatic t_crc_error();
      load_frames(3, 1'b0);
      @(negedge clk);
      drop_frame();
      chk("R6 abort on CRC mismatch", outs(), 32'b101101);
      wait_cyc(20);
      frm_valid = 1'b1;
      #1;
      chk("R6 frames ignored in error", {31'd0, cfg_we}, 32'd0);
      frm_valid = 1'b0;
      chk("R6 error latched", outs(), 32'b101101);
   endtask

   task automatic t_por_midrun();
      @(negedge clk);
      por_n = 1'b0;
      #1;
      chk("R7 power-on reset from run", outs(), 32'b101100);
      wait_cyc(3);
      por_n = 1'b1;
      wait_cyc(POR_C + CLR_C + 15);
      chk("R3 INIT released after power-on", {31'd0, init_pull}, 32'd0);
   endtask

   initial begin
      t_reset_and_first_boot();
      t_startup_order();
      t_short_program();
      t_long_program(1'b1);
      t_crc_error();
      t_long_program(1'b0);
      chk("R7 error cleared by program", {31'd0, frame_err}, 32'd0);
      t_startup_order();
      t_por_midrun();
      t_startup_order();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_NS * 200000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule